// File: doc/BRIEF.md
# DMA Flow-Control Threshold Generator

This block raises DMA service requests for a pair of byte FIFOs and a host interrupt trigger for queued transmit data. Each direction has a 3-bit block-size code. The code selects a power-of-two byte threshold. The transmit request compares the free space in the transmit FIFO against its threshold. The receive request compares the fill level of the receive FIFO against its own threshold. The comparisons differ. Transmit asks for service once at least one block of room exists. Receive asks for service only once the level has grown past one block.

A single register write carries both block-size codes. A separate write sets the 8-bit byte count that raises the host trigger. The trigger follows the number of transmit bytes queued for the host and is level-based: it drops again as soon as the queue falls below the programmed count.

All ports are plain control and status pins. The block moves no data, so it has no valid/ready stream interface and applies no back-pressure. The FIFO byte counts are sampled on every clock edge, and a request output simply reflects the most recently sampled values.

Top module: `dmafc_thresh_gen`

## Requirements
- R1: A block-size code c in the range 0..5 selects a threshold of 4·2^c bytes: 4, 8, 16, 32, 64 or 128.
- R2: Block-size codes 6 and 7 are reserved, and either one holds the request of that direction low whatever the FIFO count.
- R3: After reset both block-size codes are 2 (16 bytes), the host trigger count is 128, and all three outputs are low.
- R4: `tx_dma_req` is high when `tx_free` is greater than or equal to the transmit threshold. It is therefore high when the two are equal.
- R5: `rx_dma_req` is high only when `rx_level` is strictly greater than the receive threshold. It is low when the two are equal.
- R6: In a `blk_we` write, bits 18:16 of `blk_wdata` form the transmit code and bits 2:0 form the receive code. All other bits have no effect.
- R7: `host_trig` is high while `tx_queued` is greater than or equal to the host trigger count, and it is low while `tx_queued` is below that count.
- R8: A `trig_we` write loads `trig_wdata` as the new host trigger count.
- R9: All three outputs are registered. A change on a count input, or on a stored setting, shows at the outputs on the next rising clock edge.
- R10: While `blk_we` is low, `blk_wdata` has no effect on either block-size code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_we | input | 1 | Write strobe for the block-size codes |
| blk_wdata | input | 32 | Write data: transmit code in bits 18:16, receive code in bits 2:0 |
| trig_we | input | 1 | Write strobe for the host trigger count |
| trig_wdata | input | 8 | New host trigger count in bytes |
| rx_level | input | LVL_W (11) | Bytes held in the receive FIFO |
| tx_free | input | LVL_W (11) | Free bytes in the transmit FIFO |
| tx_queued | input | LVL_W (11) | Transmit bytes queued for the host |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| host_trig | output | 1 | Host interrupt trigger |

## Verification
The assertions assume that the count inputs are settled at every rising edge. They also assume that a write strobe lasts exactly the cycle in which its data is valid. The bench meets both assumptions by changing every input one time unit after a rising edge and by pulsing each strobe for a single cycle. The assertions also treat the reserved codes as legal values that must be absorbed without harm. For that reason the bench deliberately writes codes 6 and 7 with counts at their maximum.

// File: rtl/dmafc_pkg.sv
package dmafc_pkg;
  localparam int SEL_W    = 3;
  localparam int THR_W    = 8;
  localparam int MAX_CODE = 5;
  localparam logic [SEL_W-1:0] SEL_RST  = 3'd2;
  localparam logic [THR_W-1:0] TRIG_RST = 8'd128;

  function automatic logic code_ok(input logic [SEL_W-1:0] c);
    return c <= SEL_W'(MAX_CODE);
  endfunction

  function automatic logic [THR_W-1:0] code_bytes(input logic [SEL_W-1:0] c);
    return THR_W'(4) << c;
  endfunction
endpackage

// File: rtl/dmafc_sel_reg.sv
module dmafc_sel_reg
  import dmafc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [SEL_W-1:0] wdata_i,
  output logic [SEL_W-1:0] sel_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_o <= SEL_RST;
    else if (we_i) sel_o <= wdata_i;
  end

  // R10: no strobe, no change
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(sel_o));
  // R6: strobe loads the presented field
  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> sel_o == $past(wdata_i));
endmodule

// File: rtl/dmafc_cmp.sv
module dmafc_cmp
  import dmafc_pkg::*;
#(
  parameter int  LVL_W   = 11,
  parameter bit  STRICT  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [LVL_W-1:0] count_i,
  output logic             req_o
);
  logic [LVL_W-1:0] thr;
  logic             hit;

  assign thr = LVL_W'(code_bytes(sel_i));

  generate
    if (STRICT) begin : g_gt
      assign hit = count_i > thr;
    end else begin : g_ge
      assign hit = count_i >= thr;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_o <= 1'b0;
    else        req_o <= code_ok(sel_i) && hit;
  end

  // R2: reserved code silences the request
  a_r2_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i > SEL_W'(MAX_CODE)) |=> !req_o);

  generate
    if (STRICT) begin : g_chk_gt
      // R5: equality is not enough
      a_r5_equal_low: assert property (@(posedge clk) disable iff (!rst_n)
        (count_i == LVL_W'(4) << sel_i) |=> !req_o);
    end else begin : g_chk_ge
      // R4: equality suffices
      a_r4_equal_high: assert property (@(posedge clk) disable iff (!rst_n)
        (code_ok(sel_i) && count_i == LVL_W'(4) << sel_i) |=> req_o);
    end
  endgenerate
endmodule

// File: rtl/dmafc_trig.sv
module dmafc_trig
  import dmafc_pkg::*;
#(
  parameter int LVL_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [THR_W-1:0] wdata_i,
  input  logic [LVL_W-1:0] queued_i,
  output logic             trig_o
);
  logic [THR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= TRIG_RST;
    else if (we_i) cnt_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_o <= 1'b0;
    else        trig_o <= queued_i >= LVL_W'(cnt_q);
  end

  // R8: write loads the count
  a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> cnt_q == $past(wdata_i));
  // R7: trigger tracks queue against count
  a_r7_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (queued_i >= LVL_W'(cnt_q)) |=> trig_o);
  a_r7_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (queued_i < LVL_W'(cnt_q)) |=> !trig_o);
endmodule

// File: rtl/dmafc_thresh_gen.sv
module dmafc_thresh_gen
  import dmafc_pkg::*;
#(
  parameter int LVL_W  = 11,
  parameter int TX_LSB = 16,
  parameter int RX_LSB = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_we,
  input  logic [31:0]      blk_wdata,
  input  logic             trig_we,
  input  logic [7:0]       trig_wdata,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_free,
  input  logic [LVL_W-1:0] tx_queued,
  output logic             rx_dma_req,
  output logic             tx_dma_req,
  output logic             host_trig
);
  logic [SEL_W-1:0] tx_sel, rx_sel;
  logic             unused_bits;

  assign unused_bits = ^{blk_wdata[31:TX_LSB+SEL_W], blk_wdata[TX_LSB-1:RX_LSB+SEL_W]};

  dmafc_sel_reg u_tx_sel (
    .clk(clk), .rst_n(rst_n), .we_i(blk_we),
    .wdata_i(blk_wdata[TX_LSB +: SEL_W]), .sel_o(tx_sel));

  dmafc_sel_reg u_rx_sel (
    .clk(clk), .rst_n(rst_n), .we_i(blk_we),
    .wdata_i(blk_wdata[RX_LSB +: SEL_W]), .sel_o(rx_sel));

  dmafc_cmp #(.LVL_W(LVL_W), .STRICT(1'b0)) u_tx_cmp (
    .clk(clk), .rst_n(rst_n), .sel_i(tx_sel), .count_i(tx_free), .req_o(tx_dma_req));

  dmafc_cmp #(.LVL_W(LVL_W), .STRICT(1'b1)) u_rx_cmp (
    .clk(clk), .rst_n(rst_n), .sel_i(rx_sel), .count_i(rx_level), .req_o(rx_dma_req));

  dmafc_trig #(.LVL_W(LVL_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .we_i(trig_we), .wdata_i(trig_wdata),
    .queued_i(tx_queued), .trig_o(host_trig));

  // R9: registered outputs hold while inputs and settings hold
  a_r9_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(tx_free) && $stable(tx_sel) && !blk_we) |=> $stable(tx_dma_req));
endmodule

// File: tb/dmafc_thresh_gen_tb.sv
module dmafc_thresh_gen_tb;
  localparam int LVL_W = 11;
  logic clk = 1'b0, rst_n = 1'b0;
  logic blk_we = 1'b0, trig_we = 1'b0;
  logic [31:0] blk_wdata = '0;
  logic [7:0] trig_wdata = '0;
  logic [LVL_W-1:0] rx_level = '0, tx_free = '0, tx_queued = '0;
  logic rx_dma_req, tx_dma_req, host_trig;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dmafc_thresh_gen #(.LVL_W(LVL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .blk_we(blk_we), .blk_wdata(blk_wdata),
    .trig_we(trig_we), .trig_wdata(trig_wdata), .rx_level(rx_level),
    .tx_free(tx_free), .tx_queued(tx_queued), .rx_dma_req(rx_dma_req),
    .tx_dma_req(tx_dma_req), .host_trig(host_trig));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic int thr_of(input int c);
    return (c <= 5) ? (4 << c) : -1;
  endfunction

  task automatic write_codes(input int tx_c, input int rx_c, input logic [31:0] junk);
    blk_wdata = junk;
    blk_wdata[18:16] = 3'(tx_c);
    blk_wdata[2:0] = 3'(rx_c);
    blk_we = 1'b1; step(); blk_we = 1'b0; blk_wdata = '0;
  endtask

  task automatic t_reset();
    check(rx_dma_req, 1'b0, "R3 rx low after reset");
    check(tx_dma_req, 1'b0, "R3 tx low after reset");
    check(host_trig, 1'b0, "R3 trig low after reset");
    tx_free = 11'd16; rx_level = 11'd17; tx_queued = 11'd128; step();
    check(tx_dma_req, 1'b1, "R3 tx default 16");
    check(rx_dma_req, 1'b1, "R3 rx default 16");
    check(host_trig, 1'b1, "R3 trig default 128");
    tx_free = 11'd15; rx_level = 11'd16; tx_queued = 11'd127; step();
    check(tx_dma_req, 1'b0, "R3 tx below 16");
    check(rx_dma_req, 1'b0, "R3 rx equal 16");
    check(host_trig, 1'b0, "R3 trig below 128");
  endtask

  task automatic t_decode();
    for (int c = 0; c <= 5; c++) begin
      write_codes(c, c, '0);
      tx_free = 11'(thr_of(c) - 1); rx_level = 11'(thr_of(c)); step();
      check(tx_dma_req, 1'b0, $sformatf("R1 R4 tx code %0d below", c));
      check(rx_dma_req, 1'b0, $sformatf("R1 R5 rx code %0d equal", c));
      tx_free = 11'(thr_of(c)); rx_level = 11'(thr_of(c) + 1); step();
      check(tx_dma_req, 1'b1, $sformatf("R1 R4 tx code %0d equal", c));
      check(rx_dma_req, 1'b1, $sformatf("R1 R5 rx code %0d above", c));
    end
  endtask

  task automatic t_reserved();
    for (int c = 6; c <= 7; c++) begin
      write_codes(c, c, '0);
      tx_free = '1; rx_level = '1; step();
      check(tx_dma_req, 1'b0, $sformatf("R2 tx code %0d", c));
      check(rx_dma_req, 1'b0, $sformatf("R2 rx code %0d", c));
    end
  endtask

  task automatic t_fields();
    write_codes(0, 5, 32'hFFF8_FFF8);
    tx_free = 11'd4; rx_level = 11'd128; step();
    check(tx_dma_req, 1'b1, "R6 tx field 18:16 = 0");
    check(rx_dma_req, 1'b0, "R6 rx field 2:0 = 5");
    rx_level = 11'd129; tx_free = 11'd3; step();
    check(rx_dma_req, 1'b1, "R6 rx 129 above 128");
    check(tx_dma_req, 1'b0, "R6 tx 3 below 4");
  endtask

  task automatic t_no_strobe();
    blk_wdata = 32'h0007_0007; step(); step(); blk_wdata = '0;
    tx_free = 11'd4; rx_level = 11'd129; step();
    check(tx_dma_req, 1'b1, "R10 tx code kept without strobe");
    check(rx_dma_req, 1'b1, "R10 rx code kept without strobe");
  endtask

  task automatic t_trigger();
    trig_wdata = 8'd20; trig_we = 1'b1; step(); trig_we = 1'b0;
    tx_queued = 11'd19; step();
    check(host_trig, 1'b0, "R8 R7 19 below 20");
    tx_queued = 11'd20; step();
    check(host_trig, 1'b1, "R8 R7 20 reaches 20");
    tx_queued = 11'd300; step();
    check(host_trig, 1'b1, "R7 300 above 20");
    tx_queued = 11'd5; step();
    check(host_trig, 1'b0, "R7 drops below 20");
  endtask

  task automatic t_latency();
    write_codes(1, 1, '0);
    tx_free = 11'd0; rx_level = 11'd0; tx_queued = 11'd0; step();
    tx_free = 11'd8; rx_level = 11'd9; tx_queued = 11'd20;
    #3;
    check(tx_dma_req, 1'b0, "R9 tx old before edge");
    check(rx_dma_req, 1'b0, "R9 rx old before edge");
    check(host_trig, 1'b0, "R9 trig old before edge");
    @(posedge clk); #1;
    check(tx_dma_req, 1'b1, "R9 tx new after edge");
    check(rx_dma_req, 1'b1, "R9 rx new after edge");
    check(host_trig, 1'b1, "R9 trig new after edge");
  endtask

  initial begin
    #1;
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_decode();
    t_reserved();
    t_fields();
    t_no_strobe();
    t_trigger();
    t_latency();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule